// File: doc/BRIEF.md
# FSK-Capable Phase Accumulator Frequency Synthesizer

This block is a numerically controlled oscillator core that runs at the reference sample rate. It holds two programmable 22-bit frequency words and an 8-bit two-level FSK deviation value. A mode pin picks which of the two words is active. A transmit-data pin can add the scaled deviation to that word, which frequency-shift-keys the output. The resulting 24-bit tuning word is registered and then added every clock into a 24-bit phase accumulator. The top bit of the phase is a square-wave reference, and the full phase value is also brought out.

Software programs the block through a simple address/data/write-enable port. The mode and transmit-data pins may be asynchronous to the clock, so each passes through a two-flop synchronizer. A separate register bit turns the modulation on or off. With modulation off, the data pin has no effect.

Top module: `fsk_dds_core`

## Requirements
- R1: The phase accumulator is 24 bits wide. On every clock it adds the registered tuning word and wraps modulo 2^24.
- R2: A frequency word sits in tuning-word bits 21..0. Bits 23 and 22 of its contribution are always zero.
- R3: When the synchronized mode input is 0, the word written at address 0 is selected. When it is 1, the word written at address 1 is selected.
- R4: The deviation register holds the low 8 bits of write data at address 2 and maps onto tuning-word bits 9..2. With FSK enabled, transmit data 1 adds 4 × deviation to the selected word, and transmit data 0 adds nothing.
- R5: Write-data bit 0 at address 3 is the modulation-off bit. When it is 1, FSK is disabled and transmit data has no effect on the phase step. When it is 0, FSK is enabled.
- R6: A write takes effect on the next clock. Phase steps taken at the first edge after the write edge still use the old word, and steps from the second edge after the write edge use the new one.
- R7: While reset is high, a synchronous active-high reset clears the phase, both frequency words, the deviation and the modulation-off bit. After reset, FSK is enabled and the step is zero.
- R8: Mode and transmit data pass through a two-flop synchronizer. A change that is present at edge s first alters the phase step at edge s+3.
- R9: With a tuning word of zero, the phase holds constant. The square output always equals phase bit 23.
- R10: A carry out of the deviation add into bit 22 is kept. For example, word 0x3FFFFF with deviation 0xFF and data 1 gives a step of 0x4003FB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference sample clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 word0, 1 word1, 2 deviation, 3 modulation-off |
| wr_data | input | 22 | Write data |
| mode_sel | input | 1 | Asynchronous word select |
| tx_bit | input | 1 | Asynchronous transmit data bit |
| phase_out | output | 24 | Accumulator phase |
| ref_square | output | 1 | Square-wave reference, phase bit 23 |

## Verification
A register write changes the phase step at the second rising edge after the write edge. A change on the mode or data pin changes the phase step at the fourth rising edge counted from the edge that first samples it. The bench drives inputs and samples the phase on falling edges only. It measures each step as the difference between two consecutive falling-edge samples. Directed checks wait exactly the number of old-step edges listed above before they expect the new step. A cycle-accurate reference model built from these latencies also compares the phase and the square output on every falling edge during the random phase.

// File: rtl/fsk_dds_pkg.sv
package fsk_dds_pkg;

    localparam int ACC_W   = 24;
    localparam int WORD_W  = 22;
    localparam int DEV_W   = 8;
    localparam int DEV_LSB = 2;
    localparam int ADDR_W  = 2;
    localparam int PAD_W   = ACC_W - WORD_W;
    localparam int DEV_PAD = ACC_W - DEV_W - DEV_LSB;

    typedef enum logic [ADDR_W-1:0] {
        REG_WORD0  = 2'd0,
        REG_WORD1  = 2'd1,
        REG_DEV    = 2'd2,
        REG_MODOFF = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] word0;
        logic [WORD_W-1:0] word1;
        logic [DEV_W-1:0]  dev;
        logic              mod_off;
    } dds_cfg_t;

    typedef struct packed {
        logic mode;
        logic tx;
    } dds_ctl_t;

    function automatic logic [ACC_W-1:0] widen_word(input logic [WORD_W-1:0] w);
        return {{PAD_W{1'b0}}, w};
    endfunction

    function automatic logic [ACC_W-1:0] place_dev(input logic [DEV_W-1:0] d);
        return {{DEV_PAD{1'b0}}, d, {DEV_LSB{1'b0}}};
    endfunction

endpackage

// File: rtl/fsk_dds_cfg.sv
module fsk_dds_cfg
    import fsk_dds_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output dds_cfg_t          cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_addr))
                REG_WORD0:  cfg.word0   <= wr_data;
                REG_WORD1:  cfg.word1   <= wr_data;
                REG_DEV:    cfg.dev     <= wr_data[DEV_W-1:0];
                REG_MODOFF: cfg.mod_off <= wr_data[0];
                default:    ;
            endcase
        end
    end

    logic rst_seen_q;
    always_ff @(posedge clk) rst_seen_q <= rst;

    always_ff @(posedge clk) begin
        if (rst_seen_q === 1'b1) begin
            // R7
            cfg_cleared_chk: assert (cfg == '0)
                else $error("configuration not cleared by reset");
        end
    end

endmodule

// File: rtl/fsk_dds_sync.sv
module fsk_dds_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/fsk_dds_tune.sv
module fsk_dds_tune
    import fsk_dds_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  dds_cfg_t         cfg,
    input  dds_ctl_t         ctl,
    output logic [ACC_W-1:0] tw_q
);

    logic [WORD_W-1:0] sel_word;
    logic              fsk_add;
    logic [ACC_W-1:0]  tw_next;

    always_comb begin
        sel_word = ctl.mode ? cfg.word1 : cfg.word0;
        fsk_add  = !cfg.mod_off && ctl.tx;
        tw_next  = widen_word(sel_word) + (fsk_add ? place_dev(cfg.dev) : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) tw_q <= '0;
        else     tw_q <= tw_next;
    end

    // R2
    tw_top_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> tw_q[ACC_W-1] == 1'b0);

    // R5
    fsk_off_chk: assert property (@(posedge clk) disable iff (rst)
        cfg.mod_off |=> (tw_q[WORD_W-1:0] == $past(sel_word)) && (tw_q[ACC_W-1:WORD_W] == '0));

    // R4
    dev_low_bits_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> tw_q[DEV_LSB-1:0] == $past(sel_word[DEV_LSB-1:0]));

endmodule

// File: rtl/fsk_dds_acc.sv
module fsk_dds_acc
    import fsk_dds_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] tw,
    output logic [ACC_W-1:0] acc
);

    always_ff @(posedge clk) begin
        if (rst) acc <= '0;
        else     acc <= acc + tw;
    end

    // R9
    hold_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (tw == '0) |=> $stable(acc));

endmodule

// File: rtl/fsk_dds_core.sv
module fsk_dds_core
    import fsk_dds_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              mode_sel,
    input  logic              tx_bit,
    output logic [ACC_W-1:0]  phase_out,
    output logic              ref_square
);

    localparam int CTL_W = $bits(dds_ctl_t);

    dds_cfg_t         cfg;
    logic [CTL_W-1:0] ctl_raw;
    logic [CTL_W-1:0] ctl_sync;
    logic [ACC_W-1:0] tw;

    assign ctl_raw = {mode_sel, tx_bit};

    fsk_dds_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    fsk_dds_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ctl_raw),
        .q   (ctl_sync)
    );

    fsk_dds_tune u_tune (
        .clk  (clk),
        .rst  (rst),
        .cfg  (cfg),
        .ctl  (dds_ctl_t'(ctl_sync)),
        .tw_q (tw)
    );

    fsk_dds_acc u_acc (
        .clk (clk),
        .rst (rst),
        .tw  (tw),
        .acc (phase_out)
    );

    assign ref_square = phase_out[ACC_W-1];

endmodule

// File: tb/tb_fsk_dds_core.sv
module tb_fsk_dds_core;
    import fsk_dds_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [WORD_W-1:0] wr_data = '0;
    logic              mode_sel = 1'b0;
    logic              tx_bit = 1'b0;
    logic [ACC_W-1:0]  phase_out;
    logic              ref_square;

    int checks = 0;
    int failures = 0;
    bit chk_en = 1'b0;

    always #5 clk = ~clk;

    fsk_dds_core dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mode_sel(mode_sel), .tx_bit(tx_bit), .phase_out(phase_out), .ref_square(ref_square)
    );

    // reference model built from the requirements
    logic [WORD_W-1:0] m_w0, m_w1;
    logic [DEV_W-1:0]  m_dev;
    logic              m_off;
    logic [1:0]        m_s1, m_s2;
    logic [ACC_W-1:0]  m_tw, m_acc;

    function automatic logic [ACC_W-1:0] exp_step(input logic [WORD_W-1:0] w0, w1,
            input logic [DEV_W-1:0] dv, input logic off, input logic [1:0] mt);
        logic [ACC_W-1:0] base;
        base = {2'b00, (mt[1] ? w1 : w0)};
        if (!off && mt[0]) base = base + ({16'd0, dv} * 24'd4);
        return base;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_w0 <= '0; m_w1 <= '0; m_dev <= '0; m_off <= 1'b0;
            m_s1 <= '0; m_s2 <= '0; m_tw <= '0; m_acc <= '0;
        end else begin
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_w0 <= wr_data;
                    2'd1: m_w1 <= wr_data;
                    2'd2: m_dev <= wr_data[7:0];
                    default: m_off <= wr_data[0];
                endcase
            end
            m_s1 <= {mode_sel, tx_bit};
            m_s2 <= m_s1;
            m_tw <= exp_step(m_w0, m_w1, m_dev, m_off, m_s2);
            m_acc <= m_acc + m_tw;
        end
    end

    task automatic chk(input string tag, input logic [ACC_W-1:0] act, input logic [ACC_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en) begin
            chk("R1 model phase", phase_out, m_acc);
            chk("R9 square equals bit 23", {23'd0, ref_square}, {23'd0, m_acc[23]});
        end
    end

    task automatic wr(input logic [1:0] a, input logic [WORD_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step_chk(input string tag, input logic [ACC_W-1:0] exp);
        logic [ACC_W-1:0] p0;
        p0 = phase_out;
        @(negedge clk);
        chk(tag, phase_out - p0, exp);
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk_en = 1'b1;
        // R7 reset state
        chk("R7 phase after reset", phase_out, '0);
        chk("R7 square after reset", {23'd0, ref_square}, '0);
        // R9 zero word holds phase
        step_chk("R9 zero step", '0);
        step_chk("R9 zero step again", '0);

        // R6 write latency, R3 word0 selected with mode low
        wr(2'd0, 22'h000400);
        step_chk("R6 first edge keeps old step", '0);
        step_chk("R6 second edge uses new step", 24'h000400);
        step_chk("R3 mode low selects word0", 24'h000400);

        // R8 synchronizer latency on mode change
        wr(2'd1, 22'h012345);
        settle();
        mode_sel = 1'b1;
        step_chk("R8 edge s old", 24'h000400);
        step_chk("R8 edge s+1 old", 24'h000400);
        step_chk("R8 edge s+2 old", 24'h000400);
        step_chk("R8 edge s+3 new", 24'h012345);
        step_chk("R3 mode high selects word1", 24'h012345);

        // R4 deviation placement, upper data bits ignored
        wr(2'd2, 22'h3FFF55);
        settle();
        step_chk("R4 data low adds nothing", 24'h012345);
        tx_bit = 1'b1;
        repeat (3) @(negedge clk);
        step_chk("R4 data high adds 4*dev", 24'h012499);

        // R5 modulation off ignores data
        wr(2'd3, 22'h000001);
        settle();
        step_chk("R5 off with data high", 24'h012345);
        tx_bit = 1'b0;
        settle();
        step_chk("R5 off with data low", 24'h012345);
        tx_bit = 1'b1;
        settle();
        step_chk("R5 off data toggled high again", 24'h012345);
        wr(2'd3, 22'h000000);
        settle();
        step_chk("R5 on again", 24'h012499);

        // R10 carry into bit 22, R2 bits above word
        wr(2'd1, 22'h3FFFFF);
        wr(2'd2, 22'h0000FF);
        settle();
        step_chk("R10 carry into bit 22", 24'h4003FB);
        tx_bit = 1'b0;
        settle();
        step_chk("R2 max word keeps bits 23:22 clear", 24'h3FFFFF);

        // R1 wrap of accumulator over many steps
        repeat (20) @(negedge clk);

        // R9 zero word holds phase
        mode_sel = 1'b0;
        wr(2'd0, 22'h000000);
        settle();
        step_chk("R9 zero word holds phase", '0);

        // R7 mid-run reset clears registers
        wr(2'd0, 22'h001234);
        settle();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R7 phase cleared mid-run", phase_out, '0);
        settle();
        step_chk("R7 words cleared", '0);

        // random traffic against the model
        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            wr_en   = ($urandom % 4) == 0;
            wr_addr = 2'($urandom);
            wr_data = 22'($urandom);
            if (($urandom % 8) == 0) mode_sel = 1'($urandom);
            if (($urandom % 3) == 0) tx_bit = 1'($urandom);
        end
        @(negedge clk);
        wr_en = 1'b0;
        repeat (5) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule